// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer with Access Checking

This block translates a 40-bit virtual byte address into a 36-bit physical byte address. It caches page mappings for 16 KB pages in a 512-entry array organised as 256 sets of two ways. A lookup carries an access kind: read, write or instruction fetch. One clock later the block reports one of three outcomes: a hit with the translated address, a miss trap, or a protection trap. On a miss it does not walk any table. Software handles the trap and installs the mapping through the refill port.

Each entry holds the following state:

- a valid flag
- an 18-bit tag
- a 22-bit physical page number
- a 2-bit rights code
- a page-dirty flag
- an entry-dirty flag, meaning the cached entry differs from its in-memory copy
- a referenced flag

Each set also has one replacement bit. A maintenance port lets software do three things: clear every referenced flag at once, read back the flags and replacement bit of any entry, and invalidate the whole array in a single cycle with the flush input.

The block is a pure datapath with a per-set replacement pointer. It has no sequencing state machine: every operation completes in the cycle it is presented.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, res_paddr equals {physical page number, lk_vaddr[13:0]}. The 14 offset bits pass through unchanged. On any other outcome res_paddr is zero.
- R2: Address bits [21:14] select the set and bits [39:22] are compared with the stored tag in both ways. When both ways hold a matching valid tag, way 0 supplies the translation.
- R3: A lookup that matches no valid entry raises res_miss_trap only. It changes no entry flag and no replacement bit.
- R4: Rights codes are 00 none, 01 read-only, 10 read/write and 11 execute-and-read. lk_kind codes are 00 read, 01 write and 10 fetch; 11 behaves as read. A read needs a non-zero code, a write needs 10 and a fetch needs 11. A matching lookup that breaks this raises res_prot_trap and changes no state.
- R5: A permitted write sets the page-dirty flag. If the page was clean beforehand, the write also sets the entry-dirty flag. A write to an already dirty page leaves the entry-dirty flag unchanged.
- R6: A permitted hit sets the entry's referenced flag. A one-cycle pulse on mt_ref_clear clears the referenced flag of all 512 entries, and this pulse takes priority over a hit in the same cycle.
- R7: Results appear on the clock edge that follows lk_valid. While res_valid is high exactly one of res_hit, res_miss_trap and res_prot_trap is high. While res_valid is low none of them is.
- R8: The replacement bit of a set names the way not most recently hit or filled. An automatic refill (rf_auto=1) writes way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way the replacement bit names.
- R9: A refill with rf_auto=0 writes the way given by rf_way. Every refill installs a valid entry with the supplied tag, page number, rights and page-dirty flag, and clears the entry-dirty and referenced flags. After any refill the replacement bit names the other way.
- R10: A flush pulse clears every valid flag in one cycle. The flush wins over a refill in the same cycle.
- R11: A lookup in the same cycle as a refill of the same set and tag sees the old contents. The next lookup sees the new entry.
- R12: mt_valid, mt_pdirty, mt_tdirty and mt_ref show the entry at mt_idx and mt_way combinationally. mt_lru shows the replacement bit of set mt_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 40 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Permitted translation |
| res_miss_trap | output | 1 | No matching entry |
| res_prot_trap | output | 1 | Match found but access not allowed |
| res_paddr | output | 36 | Translated physical address |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | 26 | Virtual page number of the new entry |
| rf_auto | input | 1 | 1: hardware picks the way |
| rf_way | input | 1 | Way to write when rf_auto is 0 |
| rf_ppn | input | 22 | Physical page number |
| rf_rights | input | 2 | Rights code |
| rf_pdirty | input | 1 | Initial page-dirty flag |
| mt_ref_clear | input | 1 | Clear all referenced flags |
| mt_idx | input | 8 | Set to inspect |
| mt_way | input | 1 | Way to inspect |
| mt_valid | output | 1 | Valid flag of the inspected entry |
| mt_pdirty | output | 1 | Page-dirty flag of the inspected entry |
| mt_tdirty | output | 1 | Entry-dirty flag of the inspected entry |
| mt_ref | output | 1 | Referenced flag of the inspected entry |
| mt_lru | output | 1 | Replacement bit of the inspected set |

## Verification
The bench fills all 512 entries with computed tags, page numbers and rights. It then tries every access kind against every entry and predicts from the rights code which outcome and which dirty flags must follow. A design that mixed up a rights code would trap a legal access or let a write through to a read-only page. A design that set the entry-dirty flag unconditionally would fail on pages that were already dirty.

Directed cases cover four more corner cases. A refill must not evict a valid way while an invalid one exists. A hit must steer the replacement bit away from the hit way. A lookup that coincides with a refill of its own set must still miss. A flush must win over a refill in the same cycle. Faulting and missing lookups are then checked through the maintenance port to confirm that they left the flags and the replacement bit untouched.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Access kind carried with each lookup.
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    // Rights code stored in each entry.
    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_RO   = 2'b01,
        RT_RW   = 2'b10,
        RT_RX   = 2'b11
    } rights_e;

endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0] kind_i,
    input  logic [1:0] rights_i,
    output logic       ok_o
);
    always_comb begin
        unique case (acc_e'(kind_i))
            ACC_WRITE: ok_o = (rights_e'(rights_i) == RT_RW);
            ACC_FETCH: ok_o = (rights_e'(rights_i) == RT_RX);
            default:   ok_o = (rights_e'(rights_i) != RT_NONE);
        endcase
    end
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
    parameter int TAG_W = 18,
    parameter int PPN_W = 22,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             refclr_i,
    // lookup read port
    input  logic [SET_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic [1:0]       rd_rights_o,
    output logic [PPN_W-1:0] rd_ppn_o,
    // hit update
    input  logic             upd_en_i,
    input  logic             upd_wr_i,
    // refill port
    input  logic             fill_en_i,
    input  logic [SET_W-1:0] fill_idx_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic [1:0]       fill_rights_i,
    input  logic             fill_pdirty_i,
    output logic             fill_vld_o,
    // maintenance read port
    input  logic [SET_W-1:0] mt_idx_i,
    output logic             mt_valid_o,
    output logic             mt_pdirty_o,
    output logic             mt_tdirty_o,
    output logic             mt_ref_o
);
    localparam int NSETS = 1 << SET_W;

    logic             v_q   [NSETS];
    logic             td_q  [NSETS];
    logic             pd_q  [NSETS];
    logic             ref_q [NSETS];
    logic [TAG_W-1:0] tag_q [NSETS];
    logic [PPN_W-1:0] ppn_q [NSETS];
    logic [1:0]       rt_q  [NSETS];

    // Flag storage. Later statements take priority: update, ref clear, fill, flush.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) begin
                v_q[i]   <= 1'b0;
                td_q[i]  <= 1'b0;
                pd_q[i]  <= 1'b0;
                ref_q[i] <= 1'b0;
            end
        end else begin
            if (upd_en_i) begin
                ref_q[rd_idx_i] <= 1'b1;
                if (upd_wr_i) begin
                    pd_q[rd_idx_i] <= 1'b1;
                    if (!pd_q[rd_idx_i]) td_q[rd_idx_i] <= 1'b1;
                end
            end
            if (refclr_i) begin
                for (int i = 0; i < NSETS; i++) ref_q[i] <= 1'b0;
            end
            if (fill_en_i) begin
                v_q[fill_idx_i]   <= 1'b1;
                td_q[fill_idx_i]  <= 1'b0;
                pd_q[fill_idx_i]  <= fill_pdirty_i;
                ref_q[fill_idx_i] <= 1'b0;
            end
            if (flush_i) begin
                for (int i = 0; i < NSETS; i++) v_q[i] <= 1'b0;
            end
        end
    end

    // Payload storage, written only by refill.
    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[fill_idx_i] <= fill_tag_i;
            ppn_q[fill_idx_i] <= fill_ppn_i;
            rt_q[fill_idx_i]  <= fill_rights_i;
        end
    end

    assign rd_valid_o  = v_q[rd_idx_i];
    assign rd_tag_o    = tag_q[rd_idx_i];
    assign rd_rights_o = rt_q[rd_idx_i];
    assign rd_ppn_o    = ppn_q[rd_idx_i];
    assign fill_vld_o  = v_q[fill_idx_i];
    assign mt_valid_o  = v_q[mt_idx_i];
    assign mt_pdirty_o = pd_q[mt_idx_i];
    assign mt_tdirty_o = td_q[mt_idx_i];
    assign mt_ref_o    = ref_q[mt_idx_i];

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en_i && !flush_i) |=> v_q[$past(fill_idx_i)]); // R9

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && fill_en_i) |=> !v_q[$past(fill_idx_i)]); // R10

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int VA_W   = 40,
    parameter int PA_W   = 36,
    parameter int OFF_W  = 14,
    parameter int SET_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      lk_valid,
    input  logic [VA_W-1:0]           lk_vaddr,
    input  logic [1:0]                lk_kind,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic                      res_miss_trap,
    output logic                      res_prot_trap,
    output logic [PA_W-1:0]           res_paddr,
    input  logic                      rf_valid,
    input  logic [VA_W-OFF_W-1:0]     rf_vpn,
    input  logic                      rf_auto,
    input  logic                      rf_way,
    input  logic [PA_W-OFF_W-1:0]     rf_ppn,
    input  logic [1:0]                rf_rights,
    input  logic                      rf_pdirty,
    input  logic                      mt_ref_clear,
    input  logic [SET_W-1:0]          mt_idx,
    input  logic                      mt_way,
    output logic                      mt_valid,
    output logic                      mt_pdirty,
    output logic                      mt_tdirty,
    output logic                      mt_ref,
    output logic                      mt_lru
);
    import tlb_pkg::*;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int NSETS = 1 << SET_W;
    localparam int NWAYS = 2;

    // Lookup address split
    logic [SET_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    assign lk_idx = lk_vaddr[OFF_W +: SET_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];

    // Refill address split
    logic [SET_W-1:0] rf_idx;
    logic [TAG_W-1:0] rf_tag;
    assign rf_idx = rf_vpn[SET_W-1:0];
    assign rf_tag = rf_vpn[VPN_W-1 -: TAG_W];

    logic             rd_valid  [NWAYS];
    logic [TAG_W-1:0] rd_tag    [NWAYS];
    logic [1:0]       rd_rights [NWAYS];
    logic [PPN_W-1:0] rd_ppn    [NWAYS];
    logic             fill_vld  [NWAYS];
    logic             w_mvalid  [NWAYS];
    logic             w_mpd     [NWAYS];
    logic             w_mtd     [NWAYS];
    logic             w_mref    [NWAYS];
    logic [NWAYS-1:0] match;
    logic [NWAYS-1:0] upd_en;
    logic [NWAYS-1:0] fill_en;

    logic             lru_q [NSETS];
    logic             hit_way;
    logic             any_match;
    logic [1:0]       sel_rights;
    logic [PPN_W-1:0] sel_ppn;
    logic             perm_ok;
    logic             do_upd;
    logic             victim;
    logic             fill_way;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlb_way #(
            .TAG_W (TAG_W),
            .PPN_W (PPN_W),
            .SET_W (SET_W)
        ) u_way (
            .clk           (clk),
            .rst_n         (rst_n),
            .flush_i       (flush),
            .refclr_i      (mt_ref_clear),
            .rd_idx_i      (lk_idx),
            .rd_valid_o    (rd_valid[w]),
            .rd_tag_o      (rd_tag[w]),
            .rd_rights_o   (rd_rights[w]),
            .rd_ppn_o      (rd_ppn[w]),
            .upd_en_i      (upd_en[w]),
            .upd_wr_i      (acc_e'(lk_kind) == ACC_WRITE),
            .fill_en_i     (fill_en[w]),
            .fill_idx_i    (rf_idx),
            .fill_tag_i    (rf_tag),
            .fill_ppn_i    (rf_ppn),
            .fill_rights_i (rf_rights),
            .fill_pdirty_i (rf_pdirty),
            .fill_vld_o    (fill_vld[w]),
            .mt_idx_i      (mt_idx),
            .mt_valid_o    (w_mvalid[w]),
            .mt_pdirty_o   (w_mpd[w]),
            .mt_tdirty_o   (w_mtd[w]),
            .mt_ref_o      (w_mref[w])
        );
        assign match[w]   = rd_valid[w] && (rd_tag[w] == lk_tag);
        assign upd_en[w]  = do_upd && (hit_way == 1'(w));
        assign fill_en[w] = rf_valid && (fill_way == 1'(w));
    end

    // Way 0 wins a double match.
    assign hit_way    = !match[0];
    assign any_match  = |match;
    assign sel_rights = rd_rights[hit_way];
    assign sel_ppn    = rd_ppn[hit_way];

    tlb_perm u_perm (
        .kind_i   (lk_kind),
        .rights_i (sel_rights),
        .ok_o     (perm_ok)
    );

    assign do_upd = lk_valid && any_match && perm_ok;

    // Refill way choice: an invalid way first, otherwise the replacement pointer.
    always_comb begin
        if (!fill_vld[0])      victim = 1'b0;
        else if (!fill_vld[1]) victim = 1'b1;
        else                   victim = lru_q[rf_idx];
    end
    assign fill_way = rf_auto ? victim : rf_way;

    // Replacement pointers; a refill overrides a hit on the same set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) lru_q[i] <= 1'b0;
        end else begin
            if (do_upd)   lru_q[lk_idx] <= ~hit_way;
            if (rf_valid) lru_q[rf_idx] <= ~fill_way;
        end
    end

    // Registered lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_miss_trap <= 1'b0;
            res_prot_trap <= 1'b0;
            res_paddr     <= '0;
        end else begin
            res_valid     <= lk_valid;
            res_hit       <= do_upd;
            res_miss_trap <= lk_valid && !any_match;
            res_prot_trap <= lk_valid && any_match && !perm_ok;
            res_paddr     <= do_upd ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    assign mt_valid  = w_mvalid[mt_way];
    assign mt_pdirty = w_mpd[mt_way];
    assign mt_tdirty = w_mtd[mt_way];
    assign mt_ref    = w_mref[mt_way];
    assign mt_lru    = lru_q[mt_idx];

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_hit, res_miss_trap, res_prot_trap})); // R7

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss_trap || res_prot_trap)); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R1

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(flush) && !$past(rf_valid)) |=> !res_hit); // R10

endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = 2'b00;
    logic        res_valid, res_hit, res_miss_trap, res_prot_trap;
    logic [35:0] res_paddr;
    logic        rf_valid = 1'b0;
    logic [25:0] rf_vpn = '0;
    logic        rf_auto = 1'b0;
    logic        rf_way = 1'b0;
    logic [21:0] rf_ppn = '0;
    logic [1:0]  rf_rights = 2'b00;
    logic        rf_pdirty = 1'b0;
    logic        mt_ref_clear = 1'b0;
    logic [7:0]  mt_idx = '0;
    logic        mt_way = 1'b0;
    logic        mt_valid, mt_pdirty, mt_tdirty, mt_ref, mt_lru;

    int nvec = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss_trap(res_miss_trap),
        .res_prot_trap(res_prot_trap), .res_paddr(res_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_auto(rf_auto), .rf_way(rf_way),
        .rf_ppn(rf_ppn), .rf_rights(rf_rights), .rf_pdirty(rf_pdirty),
        .mt_ref_clear(mt_ref_clear), .mt_idx(mt_idx), .mt_way(mt_way),
        .mt_valid(mt_valid), .mt_pdirty(mt_pdirty), .mt_tdirty(mt_tdirty),
        .mt_ref(mt_ref), .mt_lru(mt_lru)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [17:0] tg(input int s, input int w);
        return 18'(s * 3 + w + 1);
    endfunction
    function automatic logic [21:0] pp(input int s, input int w);
        return 22'(s * 1031 + w * 77 + 5);
    endfunction
    function automatic logic [39:0] va(input logic [17:0] t, input int s, input int off);
        return {t, 8'(s), 14'(off)};
    endfunction

    task automatic look(input logic [39:0] a, input logic [1:0] k);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = a; lk_kind = k;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [17:0] t, input int s, input logic au, input logic w,
                        input logic [21:0] p, input logic [1:0] r, input logic pd);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = {t, 8'(s)}; rf_auto = au; rf_way = w;
        rf_ppn = p; rf_rights = r; rf_pdirty = pd;
        @(posedge clk);
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(posedge clk); @(negedge clk); flush = 1'b0;
    endtask

    task automatic mt_get(input int s, input logic w);
        mt_idx = 8'(s); mt_way = w; #0.5;
    endtask

    initial begin
        #(5.0 * 150000);
        nbad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R7 / R12
        chk("R7", {res_valid, res_hit, res_miss_trap, res_prot_trap}, 4'b0000);
        mt_get(0, 0);
        chk("R12", {mt_valid, mt_lru}, 2'b00);

        // Fill every entry with automatic way choice (R8, R9)
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 2; w++)
                fill(tg(s, w), s, 1'b1, 1'b0, pp(s, w), 2'((s + w) % 4), 1'(s >> 1));
            mt_get(s, 0); chk("R8", {mt_valid, mt_tdirty, mt_ref, mt_lru}, 4'b1000);
            mt_get(s, 1); chk("R9", {mt_valid, mt_pdirty}, {1'b1, 1'(s >> 1)});
        end

        // Sweep every access kind over every entry (R1, R2, R4, R5, R6, R7)
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 2; w++) begin
                logic [1:0] rt;
                logic pd, rok, fok, wok;
                rt  = 2'((s + w) % 4);
                pd  = 1'(s >> 1);
                rok = (rt != 2'b00);
                fok = (rt == 2'b11);
                wok = (rt == 2'b10);
                look(va(tg(s, w), s, s * 37 + w), 2'b00);
                chk("R4", {res_valid, res_hit, res_miss_trap, res_prot_trap}, {1'b1, rok, 1'b0, !rok});
                chk("R1", res_paddr, rok ? {pp(s, w), 14'(s * 37 + w)} : 36'h0);
                look(va(tg(s, w), s, 5), 2'b10);
                chk("R4", {res_hit, res_prot_trap}, {fok, !fok});
                look(va(tg(s, w), s, 9), 2'b01);
                chk("R4", {res_hit, res_prot_trap}, {wok, !wok});
                mt_get(s, 1'(w));
                chk("R5", {mt_pdirty, mt_tdirty}, {pd | wok, wok & !pd});
                chk("R6", mt_ref, rok);
            end
            look(va(18'h3FFFF, s, 1), 2'b00);
            chk("R3", {res_valid, res_hit, res_miss_trap, res_prot_trap, res_paddr}, {4'b1010, 36'h0});
        end

        // Bulk reference clear (R6)
        @(negedge clk); mt_ref_clear = 1'b1;
        @(posedge clk); @(negedge clk); mt_ref_clear = 1'b0;
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 2; w++) begin
                mt_get(s, 1'(w));
                chk("R6", {mt_valid, mt_ref}, 2'b10);
            end

        // Flush (R10)
        pulse_flush();
        for (int s = 0; s < 256; s += 15) begin
            mt_get(s, 0); chk("R10", mt_valid, 1'b0);
            mt_get(s, 1); chk("R10", mt_valid, 1'b0);
        end
        look(va(tg(10, 0), 10, 3), 2'b00);
        chk("R10", res_miss_trap, 1'b1);

        // Double match resolves to way 0 (R2), explicit way refill (R9)
        fill(18'h123, 5, 1'b0, 1'b0, 22'h0AAAA, 2'b10, 1'b0);
        fill(18'h123, 5, 1'b0, 1'b0, 22'h0AAAA, 2'b10, 1'b0);
        fill(18'h123, 5, 1'b0, 1'b1, 22'h15555, 2'b10, 1'b0);
        mt_get(5, 1); chk("R9", {mt_valid, mt_lru}, 2'b10);
        look(va(18'h123, 5, 77), 2'b00);
        chk("R2", res_paddr, {22'h0AAAA, 14'd77});
        mt_get(5, 0); chk("R8", mt_lru, 1'b1);

        // Replacement order (R8)
        pulse_flush();
        fill(18'h00A, 7, 1'b1, 1'b0, 22'h000A0, 2'b01, 1'b0);
        fill(18'h00B, 7, 1'b1, 1'b0, 22'h000B0, 2'b01, 1'b0);
        mt_get(7, 1); chk("R8", {mt_valid, mt_lru}, 2'b10);
        look(va(18'h00A, 7, 1), 2'b00);
        mt_get(7, 0); chk("R8", mt_lru, 1'b1);
        fill(18'h00C, 7, 1'b1, 1'b0, 22'h000C0, 2'b01, 1'b0);
        look(va(18'h00B, 7, 2), 2'b00);
        chk("R8", res_miss_trap, 1'b1);
        mt_get(7, 0); chk("R3", mt_lru, 1'b0);
        look(va(18'h00B, 7, 2), 2'b01);
        mt_get(7, 0); chk("R3", {mt_lru, mt_pdirty, mt_tdirty}, 3'b000);
        look(va(18'h00A, 7, 4), 2'b00);
        chk("R8", res_paddr, {22'h000A0, 14'd4});
        look(va(18'h00C, 7, 6), 2'b00);
        chk("R8", res_paddr, {22'h000C0, 14'd6});
        mt_get(7, 0); chk("R8", mt_lru, 1'b0);

        // Faults leave state alone; kind 11 reads (R4)
        fill(18'h0D0, 9, 1'b1, 1'b0, 22'h3F00F, 2'b01, 1'b0);
        look(va(18'h0D0, 9, 0), 2'b01);
        chk("R4", {res_prot_trap, res_paddr}, {1'b1, 36'h0});
        look(va(18'h0D0, 9, 0), 2'b10);
        chk("R4", res_prot_trap, 1'b1);
        mt_get(9, 0); chk("R4", {mt_pdirty, mt_tdirty, mt_ref, mt_lru}, 4'b0001);
        look(va(18'h0D0, 9, 8), 2'b11);
        chk("R4", {res_hit, res_paddr}, {1'b1, 22'h3F00F, 14'd8});
        fill(18'h0D1, 9, 1'b0, 1'b1, 22'h00001, 2'b00, 1'b0);
        look(va(18'h0D1, 9, 0), 2'b00);
        chk("R4", res_prot_trap, 1'b1);

        // Lookup concurrent with refill of the same set and tag (R11)
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va(18'h0EE, 20, 3); lk_kind = 2'b00;
        rf_valid = 1'b1; rf_vpn = {18'h0EE, 8'd20}; rf_auto = 1'b1;
        rf_ppn = 22'h2BEEF; rf_rights = 2'b10; rf_pdirty = 1'b0;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0; rf_valid = 1'b0;
        chk("R11", {res_miss_trap, res_hit}, 2'b10);
        look(va(18'h0EE, 20, 3), 2'b00);
        chk("R11", res_paddr, {22'h2BEEF, 14'd3});

        // Flush and refill in the same cycle (R10)
        @(negedge clk);
        flush = 1'b1; rf_valid = 1'b1; rf_vpn = {18'h0F0, 8'd30}; rf_auto = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0;
        mt_get(30, 0); chk("R10", mt_valid, 1'b0);
        mt_get(20, 0); chk("R10", mt_valid, 1'b0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule